// File: doc/BRIEF.md
# Program Memory Write Unlock Sequencer

This block sits between a CPU register bus and a simple memory-programming engine. Software loads a 21-bit target address into three byte-wide pointer registers, picks the target space (program flash or data EEPROM, plus a configuration-space select) and sets a write-enable bit. It then unlocks the operation by writing two key bytes to a key register that has no storage behind it, and finally sets a start bit. Only this exact, uninterrupted order releases a request to the programming engine.

While the request is outstanding, the block holds the CPU in a stall. The programming engine answers with an acknowledge. The block then drops the request, clears the start bit, releases the stall and pulses a one-cycle completion flag. Each further block of held data needs a fresh unlock.

Two resets exist. A power-on reset clears everything. A warm reset (external pin or watchdog) clears all state except a write-error flag. That flag is set when the warm reset cuts a running operation short, so software can tell that the last block may need rewriting.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: After power-on reset, the control register (address 0) and the pointer registers (addresses 2, 3, 4) read 0x00, and `prog_req`, `cpu_stall` and `prog_done` are low.
- R2: The key register (address 1) always reads 0x00, and writing to it changes no readable register.
- R3: The pointer bytes at addresses 2, 3 and 4 form `prog_addr` = {addr4[4:0], addr3, addr2}. Bits 7:5 of address 4 always read 0 and are not stored.
- R4: A program request starts when the write-enable bit (control bit 1) is already 1 and three consecutive bus writes occur: 0x55 to address 1, then 0xAA to address 1, then a control write with the start bit (bit 0) set. `prog_req` and `cpu_stall` go high in the cycle after that control write.
- R5: A start write has no effect while the stored write-enable bit is 0, even if the same write sets write-enable.
- R6: A wrong key value, or any other bus write between the first key, the second key and the start write, cancels the unlock. A start write after that has no effect until the full sequence is repeated.
- R7: While a request is outstanding, `prog_req` and `cpu_stall` stay high, control bit 0 reads 1, and bus writes are ignored. `prog_addr` therefore stays stable.
- R8: In the cycle after `prog_ack` is sampled high during a request, `prog_req` and `cpu_stall` are low, control bit 0 reads 0, and `prog_done` is high for exactly one cycle.
- R9: Control bit 5 drives `prog_flash` (1 = program flash, 0 = data EEPROM) and control bit 4 drives `prog_cfg`. Both are read back in the same positions.
- R10: A warm reset while a request is outstanding ends the request and sets the error flag (control bit 2). A warm reset clears write-enable, the space bits and the pointer, but never clears the error flag, and does not set it when no request is outstanding.
- R11: Writing 0 to control bit 2 clears the error flag, and writing 1 leaves it unchanged. Power-on reset clears it.
- R12: A completed operation consumes the unlock: a second start write without new keys has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears all state |
| rst_n | input | 1 | Warm reset, synchronous, active low, keeps the error flag |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| prog_req | output | 1 | Programming request to the memory engine |
| prog_ack | input | 1 | Programming finished, sampled while prog_req is high |
| prog_addr | output | 21 | Target address of the block being programmed |
| prog_flash | output | 1 | 1 selects program flash, 0 selects data EEPROM |
| prog_cfg | output | 1 | Selects configuration space |
| cpu_stall | output | 1 | Holds the CPU while programming runs |
| prog_done | output | 1 | One-cycle pulse when an operation completes |

## Verification
Every register write is launched on a falling edge and takes effect at the next rising edge. The bench checks its effect at the falling edge that follows, and read data, which is combinational, one time unit after the address changes. `prog_req` and `cpu_stall` are checked one cycle after the start write. The cycle after the acknowledge is checked for the falling request and the raised `prog_done`, and the cycle after that for `prog_done` being low again. A warm reset is held for one rising edge, and the error flag and cleared registers are read on the falling edge right after it. Rejected starts are checked over several cycles, to show that no request appears late.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 21;
  localparam int RADDR_W = 3;

  // register addresses (pointer lanes are contiguous from RA_PTR0)
  localparam int RA_CTRL = 0;
  localparam int RA_KEY  = 1;
  localparam int RA_PTR0 = 2;

  // control register bit positions
  localparam int CB_GO  = 0;
  localparam int CB_WEN = 1;
  localparam int CB_ERR = 2;
  localparam int CB_CFG = 4;
  localparam int CB_MEM = 5;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  // next state of the unlock checker for one bus cycle
  function automatic key_state_e key_next(key_state_e cur, logic wr, logic to_key,
                                          logic [BYTE_W-1:0] d,
                                          logic [BYTE_W-1:0] ka,
                                          logic [BYTE_W-1:0] kb);
    key_state_e n;
    n = cur;
    if (wr) begin
      unique case (cur)
        KS_IDLE: n = (to_key && d == ka) ? KS_HALF : KS_IDLE;
        KS_HALF: n = (to_key && d == kb) ? KS_ARMED : KS_IDLE;
        default: n = KS_IDLE;
      endcase
    end
    return n;
  endfunction

  // mask keeping the lowest w bits of a byte lane
  function automatic logic [BYTE_W-1:0] low_mask(int w);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) m[b] = (b < w);
    return m;
  endfunction

  // control register read image
  function automatic logic [BYTE_W-1:0] ctrl_pack(logic go, logic wen, logic err,
                                                  logic cfg, logic mem);
    logic [BYTE_W-1:0] v;
    v         = '0;
    v[CB_GO]  = go;
    v[CB_WEN] = wen;
    v[CB_ERR] = err;
    v[CB_CFG] = cfg;
    v[CB_MEM] = mem;
    return v;
  endfunction

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_unlock_pkg::*;
#(
  parameter int DW  = BYTE_W,
  parameter int RAW = RADDR_W,
  parameter logic [DW-1:0] KEY_A = 8'h55,
  parameter logic [DW-1:0] KEY_B = 8'hAA
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           armed
);

  key_state_e state_q;
  key_state_e state_d;
  logic       to_key;

  assign to_key  = (wr_addr == RAW'(RA_KEY));
  assign state_d = key_next(state_q, wr_en, to_key, wr_data, KEY_A, KEY_B);
  assign armed   = (state_q == KS_ARMED);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      state_q <= KS_IDLE;
    else if (!rst_n) state_q <= KS_IDLE;
    else             state_q <= state_d;
  end

endmodule

// File: rtl/nvm_ptr_regs.sv
module nvm_ptr_regs
  import nvm_unlock_pkg::*;
#(
  parameter int DW   = BYTE_W,
  parameter int AW   = PTR_W,
  parameter int RAW  = RADDR_W,
  parameter int BASE = RA_PTR0
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  ptr_o
);

  localparam int NB = (AW + DW - 1) / DW;

  logic [DW-1:0] lane_rd [NB];
  logic [NB-1:0] lane_hit;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int LW = ((AW - i*DW) < DW) ? (AW - i*DW) : DW;
    localparam logic [DW-1:0] MASK = low_mask(LW);

    logic [DW-1:0] q;
    logic          sel;

    assign sel = wr_en && (wr_addr == RAW'(BASE + i));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      q <= '0;
      else if (!rst_n) q <= '0;
      else if (sel)    q <= wr_data & MASK;
    end

    assign ptr_o[i*DW +: LW] = q[LW-1:0];
    assign lane_rd[i]        = q;
    assign lane_hit[i]       = (rd_addr == RAW'(BASE + i));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NB; k++)
      if (lane_hit[k]) rd_data = lane_rd[k];
  end

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int DW  = BYTE_W,
  parameter int RAW = RADDR_W
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           armed,
  input  logic           ack,
  output logic           go_q,
  output logic           wen_q,
  output logic           err_q,
  output logic           cfg_q,
  output logic           mem_q,
  output logic           done_q,
  output logic           start_fire,
  output logic           ack_fire
);

  logic ctrl_wr;

  assign ctrl_wr    = wr_en && (wr_addr == RAW'(RA_CTRL));
  assign start_fire = ctrl_wr && wr_data[CB_GO] && wen_q && armed && !go_q;
  assign ack_fire   = go_q && ack;

  // error flag: only power-on clears it from reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       err_q <= 1'b0;
    else if (!rst_n)  err_q <= err_q | go_q;
    else if (ctrl_wr) err_q <= err_q & wr_data[CB_ERR];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      go_q   <= 1'b0;
      wen_q  <= 1'b0;
      cfg_q  <= 1'b0;
      mem_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!rst_n) begin
      go_q   <= 1'b0;
      wen_q  <= 1'b0;
      cfg_q  <= 1'b0;
      mem_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= ack_fire;
      if (ack_fire)        go_q <= 1'b0;
      else if (start_fire) go_q <= 1'b1;
      if (ctrl_wr) begin
        wen_q <= wr_data[CB_WEN];
        cfg_q <= wr_data[CB_CFG];
        mem_q <= wr_data[CB_MEM];
      end
    end
  end

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int DW     = BYTE_W,
  parameter int ADDR_W = PTR_W,
  parameter int REG_AW = RADDR_W,
  parameter logic [DW-1:0] KEY_A = 8'h55,
  parameter logic [DW-1:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              prog_req,
  input  logic              prog_ack,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              prog_flash,
  output logic              prog_cfg,
  output logic              cpu_stall,
  output logic              prog_done
);

  // named internal events
  logic          key_armed;
  logic          start_fire;
  logic          ack_fire;
  logic          wr_live;
  logic          ctrl_go, ctrl_wen, ctrl_err, ctrl_cfg, ctrl_mem, ctrl_done;
  logic [DW-1:0] ptr_rd;

  // the stalled CPU cannot write; any write seen while busy is dropped
  assign wr_live = bus_we && !ctrl_go;

  nvm_key_seq #(.DW(DW), .RAW(REG_AW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .wr_en   (wr_live),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .armed   (key_armed)
  );

  nvm_prog_ctrl #(.DW(DW), .RAW(REG_AW)) u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .wr_en      (wr_live),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .armed      (key_armed),
    .ack        (prog_ack),
    .go_q       (ctrl_go),
    .wen_q      (ctrl_wen),
    .err_q      (ctrl_err),
    .cfg_q      (ctrl_cfg),
    .mem_q      (ctrl_mem),
    .done_q     (ctrl_done),
    .start_fire (start_fire),
    .ack_fire   (ack_fire)
  );

  nvm_ptr_regs #(.DW(DW), .AW(ADDR_W), .RAW(REG_AW), .BASE(RA_PTR0)) u_ptr (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .wr_en   (wr_live),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .rd_addr (bus_addr),
    .rd_data (ptr_rd),
    .ptr_o   (prog_addr)
  );

  // key register and unmapped addresses fall through to ptr_rd, which is zero there
  always_comb begin
    if (bus_addr == REG_AW'(RA_CTRL))
      bus_rdata = ctrl_pack(ctrl_go, ctrl_wen, ctrl_err, ctrl_cfg, ctrl_mem);
    else
      bus_rdata = ptr_rd;
  end

  assign prog_req   = ctrl_go;
  assign cpu_stall  = ctrl_go;
  assign prog_done  = ctrl_done;
  assign prog_flash = ctrl_mem;
  assign prog_cfg   = ctrl_cfg;

endmodule

// File: rtl/nvm_unlock_chk.sv
module nvm_unlock_chk #(
  parameter int DW     = 8,
  parameter int ADDR_W = 21,
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic              prog_req,
  input logic              prog_ack,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              prog_done,
  input logic              key_armed,
  input logic              ctrl_wen,
  input logic              ctrl_err
);

  // R4: a request only begins out of an armed checker with write-enable set
  a_r4_req_needs_unlock: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(prog_req) |-> ($past(key_armed) && $past(ctrl_wen)));

  // R7: request holds until acknowledged
  a_r7_req_held: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_req && !prog_ack) |=> prog_req);

  // R7: target address frozen during programming
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_req && $past(prog_req)) |-> $stable(prog_addr));

  // R8: acknowledge ends the request and raises done
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_req && prog_ack) |=> (prog_done && !prog_req));

  // R8: done lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    prog_done |=> !prog_done);

  // R2: key register reads zero
  a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == REG_AW'(1)) |-> (bus_rdata == '0));

  // R10: warm reset during a request leaves the error flag set
  a_r10_err_on_cut: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && prog_req) |=> ctrl_err);

  // R10: warm reset never clears the error flag
  a_r10_err_survives: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && ctrl_err) |=> ctrl_err);

endmodule

bind nvm_unlock_ctrl nvm_unlock_chk #(.DW(DW), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .prog_req  (prog_req),
  .prog_ack  (prog_ack),
  .prog_addr (prog_addr),
  .prog_done (prog_done),
  .key_armed (key_armed),
  .ctrl_wen  (ctrl_wen),
  .ctrl_err  (ctrl_err)
);

// File: tb/sim_nvm_unlock_ctrl.sv
module sim_nvm_unlock_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_KEY  = 3'd1;
  localparam logic [2:0] A_LO   = 3'd2;
  localparam logic [2:0] A_HI   = 3'd3;
  localparam logic [2:0] A_UP   = 3'd4;
  localparam logic [7:0] GO  = 8'h01;
  localparam logic [7:0] WEN = 8'h02;
  localparam logic [7:0] ERR = 8'h04;
  localparam logic [7:0] CFG = 8'h10;
  localparam logic [7:0] MEM = 8'h20;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        prog_req, prog_ack = 1'b0;
  logic [20:0] prog_addr;
  logic        prog_flash, prog_cfg, cpu_stall, prog_done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_unlock_ctrl u0 (
    .clk, .por_n, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .prog_req, .prog_ack, .prog_addr, .prog_flash, .prog_cfg, .cpu_stall, .prog_done
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic unlock_go(logic [7:0] bits);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hAA);
    wr(A_CTRL, bits | GO);
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_and_check(string tag);
    logic [7:0] v;
    @(negedge clk) prog_ack = 1'b1;
    @(negedge clk) prog_ack = 1'b0;
    chk({tag, " R8 req low"}, prog_req, 0);
    chk({tag, " R8 stall low"}, cpu_stall, 0);
    chk({tag, " R8 done high"}, prog_done, 1);
    rd(A_CTRL, v);
    chk({tag, " R8 go cleared"}, v[0], 0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, prog_done, 0);
  endtask

  task automatic power_on();
    por_n = 1'b0;
    idle_cycles(2);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    power_on();
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LO, v);   chk("R1 ptr lo", v, 0);
    rd(A_HI, v);   chk("R1 ptr hi", v, 0);
    rd(A_UP, v);   chk("R1 ptr up", v, 0);
    chk("R1 req", prog_req, 0);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 done", prog_done, 0);
  endtask

  task automatic t_pointer();
    logic [7:0] v;
    wr(A_LO, 8'h34);
    wr(A_HI, 8'h12);
    wr(A_UP, 8'hFF);
    rd(A_UP, v); chk("R3 upper masked", v, 8'h1F);
    rd(A_HI, v); chk("R3 hi readback", v, 8'h12);
    chk("R3 joined address", prog_addr, 21'h1F1234);
    wr(A_KEY, 8'h55);
    rd(A_KEY, v);  chk("R2 key reads zero", v, 0);
    rd(A_CTRL, v); chk("R2 ctrl untouched", v, 0);
    rd(A_LO, v);   chk("R2 ptr untouched", v, 8'h34);
  endtask

  task automatic t_no_wen();
    logic [7:0] v;
    wr(A_CTRL, 8'h00);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hAA);
    wr(A_CTRL, WEN | GO);
    chk("R5 no req", prog_req, 0);
    idle_cycles(3);
    chk("R5 still no req", prog_req, 0);
    rd(A_CTRL, v); chk("R5 ctrl wen only", v, WEN);
  endtask

  task automatic t_aborts();
    wr(A_CTRL, WEN);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAB); wr(A_CTRL, WEN | GO);
    idle_cycles(2);
    chk("R6 wrong second key", prog_req, 0);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_LO, 8'h40); wr(A_CTRL, WEN | GO);
    idle_cycles(2);
    chk("R6 write before start", prog_req, 0);
    wr(A_KEY, 8'h55); wr(A_HI, 8'h22); wr(A_KEY, 8'hAA); wr(A_CTRL, WEN | GO);
    idle_cycles(2);
    chk("R6 write between keys", prog_req, 0);
    wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_CTRL, WEN | GO);
    idle_cycles(2);
    chk("R6 keys reversed", prog_req, 0);
  endtask

  task automatic t_program();
    logic [7:0] v;
    logic [20:0] a0;
    wr(A_LO, 8'h80); wr(A_HI, 8'h0C); wr(A_UP, 8'h01);
    wr(A_CTRL, WEN | MEM);
    unlock_go(WEN | MEM | CFG);
    chk("R4 req next cycle", prog_req, 1);
    chk("R4 stall", cpu_stall, 1);
    chk("R9 flash select", prog_flash, 1);
    chk("R9 cfg select", prog_cfg, 1);
    rd(A_CTRL, v); chk("R7 ctrl busy image", v, WEN | MEM | CFG | GO);
    a0 = prog_addr;
    chk("R3 target address", a0, 21'h010C80);
    wr(A_LO, 8'h00);
    wr(A_CTRL, 8'h00);
    idle_cycles(3);
    chk("R7 req held", prog_req, 1);
    chk("R7 stall held", cpu_stall, 1);
    chk("R7 addr ignored write", prog_addr, a0);
    rd(A_CTRL, v); chk("R7 ctrl ignored write", v, WEN | MEM | CFG | GO);
    ack_and_check("blk1");
    wr(A_CTRL, WEN | GO);
    idle_cycles(2);
    chk("R12 second start needs keys", prog_req, 0);
    chk("R9 eeprom select", prog_flash, 0);
    chk("R9 cfg off", prog_cfg, 0);
    unlock_go(WEN);
    chk("R12 fresh keys start block 2", prog_req, 1);
    ack_and_check("blk2");
  endtask

  task automatic t_warm_cut();
    logic [7:0] v;
    wr(A_LO, 8'h11);
    wr(A_CTRL, WEN | MEM);
    unlock_go(WEN | MEM);
    chk("R4 started before cut", prog_req, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    chk("R10 req ended", prog_req, 0);
    chk("R10 stall ended", cpu_stall, 0);
    rd(A_CTRL, v); chk("R10 err only after cut", v, ERR);
    rd(A_LO, v);   chk("R10 ptr cleared", v, 0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(A_CTRL, v); chk("R10 err survives idle reset", v, ERR);
    wr(A_CTRL, ERR);
    rd(A_CTRL, v); chk("R11 write one keeps err", v, ERR);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, v); chk("R11 write zero clears err", v, 0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(A_CTRL, v); chk("R10 idle reset sets no err", v, 0);
    wr(A_CTRL, WEN);
    unlock_go(WEN);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(A_CTRL, v); chk("R10 second cut", v, ERR);
    power_on();
    rd(A_CTRL, v); chk("R11 power-on clears err", v, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_pointer();
    t_no_wen();
    t_aborts();
    t_program();
    t_warm_cut();
    idle_cycles(2);
    finish_up();
  end

endmodule